// File: doc/BRIEF.md
# Serial Memory Page-Write Controller

This block sits behind a byte-level two-wire serial receiver. It takes already decoded bus events (start, stop, and each received byte), answers every byte with an acknowledge decision, and manages writes into a 272-byte array. The array is modelled as a register file of 17 pages with 16 bytes each. A write transfer carries a device byte, then a word address, then any number of data bytes. The data is collected in a one-page staging buffer, the address counter wrapping inside the page. Nothing reaches the array until the stop event.

At stop the block applies its acceptance rules. Ordinary pages need the write-enable latch to be set. Page 80h–8Fh holds control bytes with special rules: some accept only one-byte writes, one needs an exact group of four bytes, and the rest accept no writes. An accepted transfer starts a timed commit. During the commit a busy flag is raised, the staged bytes go out on the array write port one per cycle, and all bus events are ignored. A rejected transfer is dropped whole.

Top module: `pw_ctrl`

## Requirements
- R1: The array spans byte addresses 000h–10Fh. The write port address is page*16 + offset, 9 bits wide, and never exceeds 10Fh.
- R2: `ack_valid` pulses in the cycle after each `ev_byte`, and `ack`=1 there means acknowledge. The first byte after a start is acknowledged only when its bits 7:4 are 1010 and bit 0 (the direction, 0 = write) is 0. Otherwise it is not acknowledged, and all bytes up to the next start are also not acknowledged.
- R3: The word address byte and every data byte of an accepted transfer are acknowledged. The address byte selects page = bits 7:4 and offset = bits 3:0.
- R4: Each data byte is staged at the current offset, and the offset then advances by one, wrapping from 15 to 0 with the page fixed. A byte that lands on an offset already written in the same transfer replaces the earlier byte.
- R5: Address byte FFh selects page 10h at offset 0, so the first data byte goes to 100h.
- R6: Outside page 80h–8Fh, a transfer commits only if bit 1 of the byte stored at 086h (the write-enable latch) is 1 at stop. Otherwise nothing is written.
- R7: Start addresses 80h, 85h and 86h commit only with exactly one data byte. 80h and 85h also need the latch. 86h does not need it.
- R8: Start address 81h commits only with exactly four data bytes, which go to 81h, 82h, 83h and 84h, and only with the latch set.
- R9: A transfer that breaks the control-page rules is discarded whole with no write at all. This covers a wrong byte count, or any start address 87h–8Fh.
- R10: On an accepted stop, `busy` rises in the next cycle and stays high for exactly COMMIT_CYCLES cycles. In busy cycle k (k = 0..15), offset k is written if it was staged, and nothing is written otherwise. `wr_en` is never high outside busy.
- R11: While `busy` is high, start, stop and bytes have no effect, and every byte is answered with `ack_valid`=1, `ack`=0.
- R12: A stop with no data byte, or any rejected stop, leaves `busy` low.
- R13: After reset `busy`, `ack_valid`, `ack` and `wr_en` are 0, and every array byte is 0, so the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| ev_byte | input | 1 | A byte has been received (one-cycle pulse) |
| rx_byte | input | 8 | Received byte, valid with `ev_byte` |
| ack_valid | output | 1 | Acknowledge decision is present |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| busy | output | 1 | Commit in progress, inputs ignored |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | 9 | Array write address |
| wr_data | output | 8 | Array write data |

## Verification
On every cycle, assertions check the following:
- bytes arriving while busy are refused;
- a bad device byte is never acknowledged;
- the staging offset wraps with its page fixed;
- the commit window opens right after an accepted stop and closes after its exact length;
- writes happen only inside that window and within the array.

The acceptance rules need whole transfers to show. These cover the latch being set or clear, exact byte counts at 80h/81h/85h/86h, the FFh redirect, and the wrap and overwrite order across more than sixteen bytes. Only the bench's scenarios show them, with a behavioural model that predicts every acknowledge, busy cycle and write port value.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = 4;
    localparam int PAGE_W     = 5;
    localparam int ADDR_W     = PAGE_W + OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int PAGES      = 17;
    localparam int ARRAY_BYTES = PAGES * PAGE_BYTES;
    localparam int CNT_W      = 5;

    localparam logic [3:0]        DEV_PATTERN = 4'b1010;
    localparam logic [3:0]        CTRL_HI     = 4'h8;
    localparam logic [ADDR_W-1:0] WEL_ADDR    = 9'h086;
    localparam int                WEL_BIT     = 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DEV,
        PH_ADDR,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } waddr_t;

    // Word address byte to page/offset; FFh is redirected to the last page.
    function automatic waddr_t map_start(input logic [DATA_W-1:0] a);
        waddr_t w;
        if (a == 8'hFF) begin
            w.page = PAGE_W'(PAGES - 1);
            w.off  = '0;
        end else begin
            w.page = {1'b0, a[7:4]};
            w.off  = a[3:0];
        end
        return w;
    endfunction

    // Acceptance rule evaluated at stop.
    function automatic logic write_allowed(input logic [DATA_W-1:0] sa,
                                           input logic [CNT_W-1:0]  n,
                                           input logic              wel);
        logic ok;
        if (n == '0) begin
            ok = 1'b0;
        end else if (sa[7:4] == CTRL_HI) begin
            case (sa)
                8'h81:        ok = (n == CNT_W'(4)) && wel;
                8'h80, 8'h85: ok = (n == CNT_W'(1)) && wel;
                8'h86:        ok = (n == CNT_W'(1));
                default:      ok = 1'b0;
            endcase
        end else begin
            ok = wel;
        end
        return ok;
    endfunction
endpackage

// File: rtl/pw_array.sv
module pw_array
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              wel
);
    logic [DATA_W-1:0] cells [ARRAY_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARRAY_BYTES; i++) cells[i] <= '0;
        end else if (we && (addr < ADDR_W'(ARRAY_BYTES))) begin
            cells[addr] <= data;
        end
    end

    assign wel = cells[WEL_ADDR][WEL_BIT];

    // R1: every write lands inside the array
    assert_write_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        we |-> addr < ADDR_W'(ARRAY_BYTES));
endmodule

// File: rtl/pw_stage.sv
module pw_stage
    import pw_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 init,
    input  waddr_t                               base,
    input  logic                                 push,
    input  logic [DATA_W-1:0]                    din,
    output logic [PAGE_W-1:0]                    page,
    output logic [CNT_W-1:0]                     count,
    output logic [PAGE_BYTES-1:0]                valid,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]    bytes
);
    logic [OFF_W-1:0] off;

    always_ff @(posedge clk) begin
        if (rst) begin
            page  <= '0;
            off   <= '0;
            count <= '0;
            valid <= '0;
            bytes <= '0;
        end else if (init) begin
            page  <= base.page;
            off   <= base.off;
            count <= '0;
            valid <= '0;
        end else if (push) begin
            bytes[off] <= din;
            valid[off] <= 1'b1;
            off        <= off + 1'b1;
            if (count != '1) count <= count + 1'b1;
        end
    end

    // R4: offset wraps inside the page
    assert_offset_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        push && !init && off == '1 |=> off == '0);
    // R4: page stays fixed while data is staged
    assert_page_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        push && !init |=> $stable(page));
endmodule

// File: rtl/pw_commit.sv
module pw_commit #(
    parameter int CYCLES = 24,
    localparam int SLOT_W = $clog2(CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    output logic              busy,
    output logic [SLOT_W-1:0] slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy <= 1'b1;
                slot <= '0;
            end
        end else if (slot == SLOT_W'(CYCLES - 1)) begin
            busy <= 1'b0;
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // R10: the window opens on the cycle after launch
    assert_window_open_R10: assert property (@(posedge clk) disable iff (rst)
        launch && !busy |=> busy && slot == '0);
    // R10: the window closes after its last slot
    assert_window_close_R10: assert property (@(posedge clk) disable iff (rst)
        busy && slot == SLOT_W'(CYCLES - 1) |=> !busy);
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
    import pw_pkg::*;
#(
    parameter int COMMIT_CYCLES = 24   // must be at least PAGE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        rx_byte,
    output logic              ack_valid,
    output logic              ack,
    output logic              busy,
    output logic              wr_en,
    output logic [8:0]        wr_addr,
    output logic [7:0]        wr_data
);
    localparam int SLOT_W = $clog2(COMMIT_CYCLES + 1);

    phase_t                              phase;
    logic [DATA_W-1:0]                   start_byte;
    logic                                wel;
    logic                                take_byte, dev_ok;
    logic                                stage_init, stage_push, launch;
    logic [PAGE_W-1:0]                   stage_page;
    logic [CNT_W-1:0]                    stage_count;
    logic [PAGE_BYTES-1:0]               stage_valid;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]   stage_bytes;
    logic [SLOT_W-1:0]                   slot;
    logic [OFF_W-1:0]                    slot_off;

    assign take_byte  = !busy && ev_byte && !ev_start && !ev_stop;
    assign dev_ok     = (rx_byte[7:4] == DEV_PATTERN) && !rx_byte[0];
    assign stage_init = take_byte && (phase == PH_ADDR);
    assign stage_push = take_byte && (phase == PH_DATA);
    assign launch     = !busy && ev_stop && !ev_start && (phase == PH_DATA)
                        && write_allowed(start_byte, stage_count, wel);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            start_byte <= '0;
            ack_valid  <= 1'b0;
            ack        <= 1'b0;
        end else begin
            ack_valid <= ev_byte;
            ack       <= 1'b0;
            if (!busy) begin
                if (ev_start) begin
                    phase <= PH_DEV;
                end else if (ev_stop) begin
                    phase <= PH_IDLE;
                end else if (ev_byte) begin
                    case (phase)
                        PH_DEV: begin
                            ack   <= dev_ok;
                            phase <= dev_ok ? PH_ADDR : PH_IDLE;
                        end
                        PH_ADDR: begin
                            ack        <= 1'b1;
                            start_byte <= rx_byte;
                            phase      <= PH_DATA;
                        end
                        PH_DATA: ack <= 1'b1;
                        default: ack <= 1'b0;
                    endcase
                end
            end
        end
    end

    pw_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .init  (stage_init),
        .base  (map_start(rx_byte)),
        .push  (stage_push),
        .din   (rx_byte),
        .page  (stage_page),
        .count (stage_count),
        .valid (stage_valid),
        .bytes (stage_bytes)
    );

    pw_commit #(.CYCLES(COMMIT_CYCLES)) u_commit (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy),
        .slot   (slot)
    );

    assign slot_off = slot[OFF_W-1:0];
    assign wr_en    = busy && (slot < SLOT_W'(PAGE_BYTES)) && stage_valid[slot_off];
    assign wr_addr  = {stage_page, slot_off};
    assign wr_data  = stage_bytes[slot_off];

    pw_array u_array (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .addr (wr_addr),
        .data (wr_data),
        .wel  (wel)
    );

    // R11: bytes during the commit are refused
    assert_busy_nack_R11: assert property (@(posedge clk) disable iff (rst)
        busy && ev_byte |=> ack_valid && !ack);
    // R2: a bad device byte is never acknowledged
    assert_dev_filter_R2: assert property (@(posedge clk) disable iff (rst)
        take_byte && phase == PH_DEV && (rx_byte[7:4] != DEV_PATTERN || rx_byte[0])
        |=> !ack);
    // R10: array writes only inside the commit window
    assert_write_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);
    // R12: a stop outside the data phase never opens a commit
    assert_no_commit_outside_data_R12: assert property (@(posedge clk) disable iff (rst)
        !busy && ev_stop && phase != PH_DATA |=> !busy);
endmodule

// File: tb/pw_ctrl_test.sv
module pw_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int COMMIT     = 24;

    logic clk, rst, ev_start, ev_stop, ev_byte;
    logic [7:0] rx_byte;
    logic ack_valid, ack, busy, wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int failures = 0;
    string cur_req = "R13";

    pw_ctrl #(.COMMIT_CYCLES(COMMIT)) uut (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .rx_byte(rx_byte), .ack_valid(ack_valid), .ack(ack),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_phase;        // 0 idle, 1 device, 2 address, 3 data
    int m_left, m_idx, m_page, m_off, m_start, m_cnt, c_page;
    int sd[16];
    bit sv[16];
    int cd[16];
    bit cv[16];
    int mem[272];
    bit e_ackv, e_ack, e_busy, e_wren;
    int e_waddr, e_wdata;

    function automatic bit rule_ok();
        bit wel;
        wel = mem[134][1];
        if (m_cnt == 0) return 0;
        if (m_start >= 128 && m_start <= 143) begin
            if (m_start == 129) return (m_cnt == 4) && wel;
            if (m_start == 128 || m_start == 133) return (m_cnt == 1) && wel;
            if (m_start == 134) return m_cnt == 1;
            return 0;
        end
        return wel;
    endfunction

    task automatic model_reset();
        m_phase = 0; m_left = 0; m_idx = 0; m_page = 0; m_off = 0;
        m_start = 0; m_cnt = 0; c_page = 0;
        for (int i = 0; i < 16; i++) begin sd[i] = 0; sv[i] = 0; cd[i] = 0; cv[i] = 0; end
        for (int i = 0; i < 272; i++) mem[i] = 0;
        e_ackv = 0; e_ack = 0; e_busy = 0; e_wren = 0; e_waddr = 0; e_wdata = 0;
    endtask

    task automatic model_edge(bit s, bit p, bit b, int d);
        bit was_busy;
        was_busy = m_left > 0;
        if (was_busy) begin
            if (m_idx < 16 && cv[m_idx]) mem[c_page * 16 + m_idx] = cd[m_idx];
            m_idx++;
            m_left--;
        end
        e_ackv = b;
        e_ack  = 0;
        if (!was_busy) begin
            if (s) m_phase = 1;
            else if (p) begin
                if (m_phase == 3 && rule_ok()) begin
                    m_left = COMMIT; m_idx = 0; c_page = m_page;
                    for (int i = 0; i < 16; i++) begin cd[i] = sd[i]; cv[i] = sv[i]; end
                end
                m_phase = 0;
            end else if (b) begin
                if (m_phase == 1) begin
                    if ((d >> 4) == 10 && (d % 2) == 0) begin e_ack = 1; m_phase = 2; end
                    else m_phase = 0;
                end else if (m_phase == 2) begin
                    e_ack = 1; m_start = d; m_cnt = 0; m_phase = 3;
                    if (d == 255) begin m_page = 16; m_off = 0; end
                    else begin m_page = d / 16; m_off = d % 16; end
                    for (int i = 0; i < 16; i++) sv[i] = 0;
                end else if (m_phase == 3) begin
                    e_ack = 1; sd[m_off] = d; sv[m_off] = 1;
                    m_off = (m_off + 1) % 16; m_cnt++;
                end
            end
        end
        e_busy = m_left > 0;
        e_wren = e_busy && m_idx < 16 && cv[m_idx];
        if (e_wren) begin e_waddr = c_page * 16 + m_idx; e_wdata = cd[m_idx]; end
    endtask

    task automatic compare();
        checks++;
        if (ack_valid !== e_ackv || ack !== e_ack || busy !== e_busy || wr_en !== e_wren ||
            (e_wren && (wr_addr !== 9'(e_waddr) || wr_data !== 8'(e_wdata)))) begin
            failures++;
            $display("FAIL %s t=%0t actual ackv=%b ack=%b busy=%b we=%b addr=%h data=%h expected ackv=%b ack=%b busy=%b we=%b addr=%h data=%h",
                     cur_req, $time, ack_valid, ack, busy, wr_en, wr_addr, wr_data,
                     e_ackv, e_ack, e_busy, e_wren, 9'(e_waddr), 8'(e_wdata));
        end
    endtask

    task automatic tick(bit s, bit p, bit b, logic [7:0] d);
        @(negedge clk);
        ev_start = s; ev_stop = p; ev_byte = b; rx_byte = d;
        model_edge(s, p, b, int'(d));
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 8'h00);
    endtask

    task automatic do_start();      tick(1, 0, 0, 8'h00); idle(1); endtask
    task automatic do_stop();       tick(0, 1, 0, 8'h00); endtask
    task automatic do_byte(logic [7:0] d); tick(0, 0, 1, d); idle(1); endtask

    // full write transfer: device A0, address, n data bytes from seed, stop, drain
    task automatic xfer(logic [7:0] a, int n, int seed);
        do_start();
        do_byte(8'hA0);
        do_byte(a);
        for (int i = 0; i < n; i++) do_byte(8'(seed + i));
        do_stop();
        idle(COMMIT + 2);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        ev_start = 0; ev_stop = 0; ev_byte = 0; rx_byte = 0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R13";
        compare();                             // R13 reset outputs
        @(negedge clk);
        rst = 0;
        idle(2);

        cur_req = "R6 latch clear";            // R6 page write refused without latch
        xfer(8'h10, 3, 8'h11);
        cur_req = "R12 empty stop";            // R12 stop with no data
        xfer(8'h20, 0, 0);
        cur_req = "R7 set latch at 86h";       // R7 single byte to 86h, no latch needed
        xfer(8'h86, 1, 8'h02);
        cur_req = "R4 R10 wrap from offset 11"; // R4 12 bytes wrap, R10 ascending order
        xfer(8'h2B, 12, 8'h40);
        cur_req = "R4 overwrite beyond 16";    // R4 18 bytes overwrite
        xfer(8'h30, 18, 8'h60);
        cur_req = "R5 R1 FFh redirect";        // R5 R1 page at 100h
        xfer(8'hFF, 3, 8'hC0);
        cur_req = "R8 group of four";          // R8 81h exactly four
        xfer(8'h81, 4, 8'h90);
        cur_req = "R9 R8 group of three";      // R9 wrong count discarded
        xfer(8'h81, 3, 8'hA0);
        cur_req = "R9 R8 group of five";
        xfer(8'h81, 5, 8'hA8);
        cur_req = "R7 R9 two bytes at 80h";    // R7 multi-byte to single-byte location
        xfer(8'h80, 2, 8'hB0);
        cur_req = "R7 one byte at 85h";
        xfer(8'h85, 1, 8'hB5);
        cur_req = "R9 page write at 88h";      // R9 reserved window start
        xfer(8'h88, 4, 8'hD0);
        cur_req = "R3 one byte page 0";        // R3 acks and page/offset split
        xfer(8'h07, 1, 8'h77);

        cur_req = "R2 bad device byte";        // R2 wrong pattern, then everything refused
        do_start(); do_byte(8'hB0); do_byte(8'h10); do_byte(8'h55); do_stop(); idle(4);
        cur_req = "R2 read direction";         // R2 direction bit 1 refused
        do_start(); do_byte(8'hA1); do_byte(8'h10); do_stop(); idle(4);

        cur_req = "R11 inputs during busy";    // R11 events during commit ignored
        do_start(); do_byte(8'hA0); do_byte(8'h50); do_byte(8'h5A); do_stop();
        do_start(); do_byte(8'hA0); do_byte(8'h60); do_byte(8'h66); do_stop();
        idle(COMMIT + 2);

        cur_req = "R7 clear latch";            // R7 86h written with 00h
        xfer(8'h86, 1, 8'h00);
        cur_req = "R6 latch cleared again";    // R6 refused after clearing
        xfer(8'h40, 2, 8'h44);

        summary();
        $finish;
    end
endmodule